// File: doc/BRIEF.md
# Segment Memory Access Checker

This block judges whether one memory access made through an already loaded segment is legal. For each request it takes the byte offset, the access width, and the kind of access (read, write or instruction fetch), together with the cached descriptor attributes. These attributes are the 20-bit raw limit, the granularity flag, the expand-down flag, the default/big flag, the code/data flag, the readable/writable flag and a null marker. A mode input says whether the processor runs with a flat 64-bit address space.

One clock after the request, a registered verdict appears. It reports either success or a fault with a two-bit cause. Inside the block, the raw limit is widened by the granularity flag, and the offset range is inverted for expand-down segments, with the upper end chosen by the big flag. Permission rules for code and data segments are also applied. Base addition, paging and fault delivery belong to other blocks.

Top module: `seg_access_chk`

## Requirements
- R1: A request sampled with `req_valid` high yields `rsp_valid` high on the next clock edge. In any cycle after a clock with no request, `rsp_valid`, `rsp_ok` and `rsp_cause` are all zero. Reset clears all three.
- R2: With the granularity flag at 0, the effective limit is the raw limit zero-extended, so its largest value is 0xFFFFF.
- R3: With the granularity flag at 1, the effective limit is the raw limit shifted left by 12 with the low 12 bits set to one, so its largest value is 0xFFFFFFFF.
- R4: For a normal segment, the last byte is at offset + `req_size`, where `req_size` holds the byte count minus one. That last byte must not exceed the effective limit. A carry out of 32 bits in this sum is a limit fault.
- R5: For an expand-down segment, the first byte must be at or above the effective limit. The last byte must not exceed the upper bound, which is 0xFFFF when the big flag is 0 and 0xFFFFFFFF when it is 1. A carry out of 32 bits is a limit fault.
- R6: A write (kind 1) faults with a type cause when it targets a code segment, or a data segment whose read/write flag is 0.
- R7: A read (kind 0) faults with a type cause when it targets a code segment whose read/write flag is 0. Reads from data segments are always permitted.
- R8: A fetch (kind 2) is permitted only from a code segment, whatever its read/write flag. Kind 3 always gives a type fault.
- R9: Outside 64-bit mode, an access through a null segment faults with the null cause, whatever its other properties.
- R10: In 64-bit mode, neither the null check nor any limit check is applied, but type checks still are.
- R11: The cause codes are 0 for none, 1 for null, 2 for type and 3 for limit. When several apply, null wins over type and type wins over limit. `rsp_ok` is high exactly when a response carries cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_offset | input | 32 | Offset of the first byte |
| req_size | input | 3 | Byte count minus one |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| desc_limit_raw | input | 20 | Raw segment limit |
| desc_gran | input | 1 | Granularity flag, 1 selects 4 KiB units |
| desc_expdn | input | 1 | Expand-down flag |
| desc_big | input | 1 | Default/big flag, selects the expand-down upper bound |
| desc_code | input | 1 | 1 for a code segment, 0 for data |
| desc_rw | input | 1 | Readable (code) or writable (data) |
| desc_null | input | 1 | Segment register holds a null selector |
| mode64 | input | 1 | 64-bit flat mode |
| rsp_valid | output | 1 | Verdict present |
| rsp_ok | output | 1 | Access permitted |
| rsp_cause | output | 2 | Fault cause code |

## Verification
The assertions assume that the descriptor fields and the mode flag are stable and known during any cycle in which `req_valid` is high. They also assume that `req_kind` is a two-bit value whose reserved code is deliberately tested. The stimulus changes inputs only at falling clock edges, and it sets the descriptor before raising the strobe. Each request is held for exactly one clock, so every verdict is tied to a single sampled set of inputs.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CZ_NONE  = 2'd0,
    CZ_NULL  = 2'd1,
    CZ_TYPE  = 2'd2,
    CZ_LIMIT = 2'd3
  } fault_cause_e;

endpackage

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
  parameter int RAW_W   = 20,
  parameter int OFS_W   = 32,
  parameter int GRAN_SH = 12
) (
  input  logic [RAW_W-1:0] raw_limit,
  input  logic             gran,
  output logic [OFS_W-1:0] eff_limit
);

  localparam int WIDE_W = RAW_W + GRAN_SH;

  function automatic logic [OFS_W-1:0] fine_limit(input logic [RAW_W-1:0] r);
    return OFS_W'(r);
  endfunction

  logic [OFS_W-1:0] coarse;

  generate
    if (GRAN_SH == 0) begin : g_no_shift
      assign coarse = OFS_W'(raw_limit);
    end else begin : g_shift
      logic [WIDE_W-1:0] wide;
      assign wide   = {raw_limit, {GRAN_SH{1'b1}}};
      assign coarse = OFS_W'(wide);
    end
  endgenerate

  assign eff_limit = gran ? coarse : fine_limit(raw_limit);

endmodule

// File: rtl/seg_range_chk.sv
module seg_range_chk #(
  parameter int OFS_W      = 32,
  parameter int SZ_W       = 3,
  parameter int SMALL_UB_W = 16
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [SZ_W-1:0]  size_m1,
  input  logic [OFS_W-1:0] eff_limit,
  input  logic             expdn,
  input  logic             big,
  output logic             carry_out,
  output logic             range_bad
);

  localparam int SUM_W = OFS_W + 1;

  function automatic logic [SUM_W-1:0] last_byte(input logic [OFS_W-1:0] o,
                                                 input logic [SZ_W-1:0]  s);
    return {1'b0, o} + SUM_W'(s);
  endfunction

  function automatic logic [OFS_W-1:0] top_bound(input logic b);
    return b ? {OFS_W{1'b1}} : OFS_W'({SMALL_UB_W{1'b1}});
  endfunction

  logic [SUM_W-1:0] last_sum;
  logic [OFS_W-1:0] last_ofs;
  logic [OFS_W-1:0] ub;
  logic             up_bad;
  logic             exp_bad;

  assign last_sum  = last_byte(offset, size_m1);
  assign carry_out = last_sum[OFS_W];
  assign last_ofs  = last_sum[OFS_W-1:0];
  assign ub        = top_bound(big);
  assign up_bad    = last_ofs > eff_limit;
  assign exp_bad   = (offset < eff_limit) || (last_ofs > ub);

  always_comb begin
    if (carry_out)  range_bad = 1'b1;
    else if (expdn) range_bad = exp_bad;
    else            range_bad = up_bad;
  end

endmodule

// File: rtl/seg_perm_chk.sv
module seg_perm_chk
  import seg_chk_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       is_code,
  input  logic       rw,
  output logic       perm_bad
);

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_READ:  perm_bad = is_code && !rw;
      ACC_WRITE: perm_bad = is_code || !rw;
      ACC_FETCH: perm_bad = !is_code;
      default:   perm_bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import seg_chk_pkg::*;
#(
  parameter int OFS_W      = 32,
  parameter int RAW_W      = 20,
  parameter int GRAN_SH    = 12,
  parameter int SZ_W       = 3,
  parameter int SMALL_UB_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [SZ_W-1:0]  req_size,
  input  logic [1:0]       req_kind,
  input  logic [RAW_W-1:0] desc_limit_raw,
  input  logic             desc_gran,
  input  logic             desc_expdn,
  input  logic             desc_big,
  input  logic             desc_code,
  input  logic             desc_rw,
  input  logic             desc_null,
  input  logic             mode64,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [1:0]       rsp_cause
);

  logic [OFS_W-1:0] eff_limit;
  logic             carry_out;
  logic             range_bad;
  logic             perm_bad;
  logic             null_hit;
  logic             limit_hit;
  logic             type_hit;
  fault_cause_e     cause_d;

  seg_limit_scale #(
    .RAW_W  (RAW_W),
    .OFS_W  (OFS_W),
    .GRAN_SH(GRAN_SH)
  ) u_scale (
    .raw_limit(desc_limit_raw),
    .gran     (desc_gran),
    .eff_limit(eff_limit)
  );

  seg_range_chk #(
    .OFS_W     (OFS_W),
    .SZ_W      (SZ_W),
    .SMALL_UB_W(SMALL_UB_W)
  ) u_range (
    .offset   (req_offset),
    .size_m1  (req_size),
    .eff_limit(eff_limit),
    .expdn    (desc_expdn),
    .big      (desc_big),
    .carry_out(carry_out),
    .range_bad(range_bad)
  );

  seg_perm_chk u_perm (
    .kind    (req_kind),
    .is_code (desc_code),
    .rw      (desc_rw),
    .perm_bad(perm_bad)
  );

  assign null_hit  = !mode64 && desc_null;
  assign limit_hit = !mode64 && (range_bad || carry_out);
  assign type_hit  = perm_bad;

  always_comb begin
    if (null_hit)       cause_d = CZ_NULL;
    else if (type_hit)  cause_d = CZ_TYPE;
    else if (limit_hit) cause_d = CZ_LIMIT;
    else                cause_d = CZ_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_cause <= 2'd0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && (cause_d == CZ_NONE);
      rsp_cause <= req_valid ? cause_d : CZ_NONE;
    end
  end

endmodule

// File: rtl/seg_access_chk_sva.sv
module seg_access_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       desc_code,
  input logic       desc_null,
  input logic       mode64,
  input logic       null_hit,
  input logic       type_hit,
  input logic       limit_hit,
  input logic       rsp_valid,
  input logic       rsp_ok,
  input logic [1:0] rsp_cause
);

  p_resp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok && rsp_cause == 2'd0));

  p_ok_means_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok == (rsp_cause == 2'd0)));

  p_write_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && desc_code && !null_hit) |=> (!rsp_ok && rsp_cause == 2'd2));

  p_fetch_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2 && !desc_code && !null_hit) |=> (rsp_cause == 2'd2));

  p_null_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode64 && desc_null) |=> (rsp_cause == 2'd1));

  p_flat_skips_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode64) |=> (rsp_cause != 2'd1 && rsp_cause != 2'd3));

  p_limit_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && limit_hit && !null_hit && !type_hit) |=> (rsp_cause == 2'd3));

endmodule

bind seg_access_chk seg_access_chk_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .desc_code (desc_code),
  .desc_null (desc_null),
  .mode64    (mode64),
  .null_hit  (null_hit),
  .type_hit  (type_hit),
  .limit_hit (limit_hit),
  .rsp_valid (rsp_valid),
  .rsp_ok    (rsp_ok),
  .rsp_cause (rsp_cause)
);

// File: tb/seg_access_chk_tb.sv
module seg_access_chk_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic [19:0] desc_limit_raw = '0;
  logic        desc_gran = 1'b0;
  logic        desc_expdn = 1'b0;
  logic        desc_big = 1'b0;
  logic        desc_code = 1'b0;
  logic        desc_rw = 1'b1;
  logic        desc_null = 1'b0;
  logic        mode64 = 1'b0;
  logic        rsp_valid;
  logic        rsp_ok;
  logic [1:0]  rsp_cause;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2, K_RS = 2'd3;
  localparam logic [1:0] C_NONE = 2'd0, C_NULL = 2'd1, C_TYPE = 2'd2, C_LIM = 2'd3;

  always #5 clk = ~clk;

  seg_access_chk u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_size(req_size), .req_kind(req_kind), .desc_limit_raw(desc_limit_raw),
    .desc_gran(desc_gran), .desc_expdn(desc_expdn), .desc_big(desc_big),
    .desc_code(desc_code), .desc_rw(desc_rw), .desc_null(desc_null),
    .mode64(mode64), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_cause(rsp_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_desc(input logic [19:0] raw, input logic g, input logic e,
                          input logic b, input logic code, input logic rw,
                          input logic nul, input logic m64);
    @(negedge clk);
    desc_limit_raw = raw; desc_gran = g; desc_expdn = e; desc_big = b;
    desc_code = code; desc_rw = rw; desc_null = nul; mode64 = m64;
  endtask

  task automatic access(input string tag, input logic [1:0] kind, input logic [31:0] off,
                        input logic [2:0] sz, input logic exp_ok, input logic [1:0] exp_cause);
    @(negedge clk);
    req_kind = kind; req_offset = off; req_size = sz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " ok"}, 32'(rsp_ok), 32'(exp_ok));
    chk({tag, " cause"}, 32'(rsp_cause), 32'(exp_cause));
    @(negedge clk);
    chk({tag, " R1 idle"}, 32'({rsp_valid, rsp_ok, rsp_cause}), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset ok", 32'(rsp_ok), 32'd0);
    chk("R1 reset cause", 32'(rsp_cause), 32'd0);
  endtask

  task automatic t_fine_limit();
    set_desc(20'h00FFF, 0, 0, 1, 0, 1, 0, 0);
    access("R2 at limit", K_RD, 32'h0000_0FFF, 3'd0, 1, C_NONE);
    access("R2 past limit", K_RD, 32'h0000_1000, 3'd0, 0, C_LIM);
    access("R4 4B fits", K_RD, 32'h0000_0FFC, 3'd3, 1, C_NONE);
    access("R4 4B straddles", K_RD, 32'h0000_0FFD, 3'd3, 0, C_LIM);
  endtask

  task automatic t_coarse_limit();
    set_desc(20'h00001, 1, 0, 1, 0, 1, 0, 0);
    access("R3 top of 2 pages", K_RD, 32'h0000_1FFF, 3'd0, 1, C_NONE);
    access("R3 beyond", K_RD, 32'h0000_2000, 3'd0, 0, C_LIM);
    set_desc(20'hFFFFF, 1, 0, 1, 0, 1, 0, 0);
    access("R3 full span", K_RD, 32'hFFFF_FFFC, 3'd3, 1, C_NONE);
    access("R4 carry", K_RD, 32'hFFFF_FFFD, 3'd3, 0, C_LIM);
  endtask

  task automatic t_expand_down();
    set_desc(20'h01000, 0, 1, 0, 0, 1, 0, 0);
    access("R5 at limit", K_RD, 32'h0000_1000, 3'd0, 1, C_NONE);
    access("R5 below limit", K_RD, 32'h0000_0FFF, 3'd0, 0, C_LIM);
    access("R5 small top", K_RD, 32'h0000_FFFE, 3'd1, 1, C_NONE);
    access("R5 past small top", K_RD, 32'h0000_FFFF, 3'd1, 0, C_LIM);
    access("R5 far above", K_WR, 32'h0001_0000, 3'd0, 0, C_LIM);
    set_desc(20'h01000, 0, 1, 1, 0, 1, 0, 0);
    access("R5 big above 64K", K_WR, 32'h0001_0000, 3'd0, 1, C_NONE);
    access("R5 big top byte", K_RD, 32'hFFFF_FFFF, 3'd0, 1, C_NONE);
    access("R5 big carry", K_RD, 32'hFFFF_FFFF, 3'd1, 0, C_LIM);
  endtask

  task automatic t_write_rules();
    set_desc(20'hFFFFF, 0, 0, 1, 0, 1, 0, 0);
    access("R6 write rw data", K_WR, 32'h10, 3'd7, 1, C_NONE);
    set_desc(20'hFFFFF, 0, 0, 1, 0, 0, 0, 0);
    access("R6 write ro data", K_WR, 32'h10, 3'd0, 0, C_TYPE);
    access("R7 read ro data", K_RD, 32'h10, 3'd0, 1, C_NONE);
    set_desc(20'hFFFFF, 0, 0, 1, 1, 1, 0, 0);
    access("R6 write code", K_WR, 32'h10, 3'd0, 0, C_TYPE);
  endtask

  task automatic t_read_fetch();
    set_desc(20'hFFFFF, 0, 0, 1, 1, 0, 0, 0);
    access("R7 read exec-only", K_RD, 32'h20, 3'd0, 0, C_TYPE);
    access("R8 fetch exec-only", K_EX, 32'h20, 3'd0, 1, C_NONE);
    access("R8 reserved kind", K_RS, 32'h20, 3'd0, 0, C_TYPE);
    set_desc(20'hFFFFF, 0, 0, 1, 1, 1, 0, 0);
    access("R7 read readable code", K_RD, 32'h20, 3'd0, 1, C_NONE);
    set_desc(20'hFFFFF, 0, 0, 1, 0, 1, 0, 0);
    access("R8 fetch data", K_EX, 32'h20, 3'd0, 0, C_TYPE);
  endtask

  task automatic t_null_and_flat();
    set_desc(20'h00010, 0, 0, 1, 1, 1, 1, 0);
    access("R9 null wins", K_WR, 32'h0010_0000, 3'd0, 0, C_NULL);
    set_desc(20'h00010, 0, 0, 1, 0, 1, 1, 1);
    access("R10 flat no null/limit", K_RD, 32'h0010_0000, 3'd7, 1, C_NONE);
    access("R10 flat carry ignored", K_RD, 32'hFFFF_FFFF, 3'd7, 1, C_NONE);
    set_desc(20'h00010, 0, 0, 1, 1, 1, 1, 1);
    access("R10 flat type kept", K_WR, 32'h0, 3'd0, 0, C_TYPE);
  endtask

  task automatic t_priority_b2b();
    set_desc(20'h00010, 0, 0, 1, 0, 0, 0, 0);
    access("R11 type over limit", K_WR, 32'h0000_1000, 3'd0, 0, C_TYPE);
    @(negedge clk);
    req_kind = K_RD; req_offset = 32'h0000_1000; req_size = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_kind = K_RD; req_offset = 32'h0000_0008; req_size = 3'd0;
    chk("R1 b2b first valid", 32'(rsp_valid), 32'd1);
    chk("R1 b2b first cause", 32'(rsp_cause), 32'(C_LIM));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b second ok", 32'(rsp_ok), 32'd1);
    chk("R11 b2b second cause", 32'(rsp_cause), 32'(C_NONE));
    @(negedge clk);
    chk("R1 b2b idle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fine_limit();
    t_coarse_limit();
    t_expand_down();
    t_write_rules();
    t_read_fetch();
    t_null_and_flat();
    t_priority_b2b();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule